// File: doc/BRIEF.md
# Top-Relative Extended-Precision Register Stack

This block is the register storage of a floating-point unit. It holds eight 80-bit extended-precision values in a circular file and names each one by its distance from a rotating top pointer: ST(0) is the entry the pointer designates, and ST(i) is physical entry (top + i) mod 8. Every cycle it takes one decoded command: a push, a pop, an exchange, or a compute step. The command carries a 3-bit offset, a reverse-destination bit and a pop-after bit.

For a compute step the block drives two operands to an external arithmetic unit, all within the same cycle. The first is always ST(0). The second is ST(i), or a value supplied from outside for memory-style operands. The unit's result comes back on `res_data` and is written into the selected destination at the clock edge. A pop can follow in that same edge. The exchange command swaps ST(0) with any ST(i) in one cycle, so ST(0) can serve as an accumulator over the other seven entries.

Each physical entry carries a valid tag. Two sticky error flags report a push into an occupied slot (overflow) and a read of an empty entry (underflow). A command that raises either flag changes neither the data, nor the tags, nor the pointer.

Top module: `fp_regstack`

## Requirements
- R1: While `rst` is high at a clock edge, the top pointer becomes 0 and all valid tags and both flags become 0.
- R2: `opa` always shows ST(0) and `opb` shows ST(`cmd_idx`), both combinationally from the current pointer. The exception is the external binary command (op=6), where `opb` shows `ext_data`.
- R3: A push (op=1) decrements the pointer modulo 8, stores `push_data` as the new ST(0) and marks that entry valid. If the slot below the pointer is already valid, the overflow flag is set instead, and the pointer, tags and data stay unchanged.
- R4: A pop (op=2) clears the tag of the current top entry and increments the pointer modulo 8. If ST(0) is empty, the underflow flag is set instead and nothing else changes.
- R5: An exchange (op=3) swaps the values of ST(0) and ST(`cmd_idx`) in a single cycle and leaves the pointer and the tags unchanged.
- R6: A unary compute (op=4) writes `res_data` into ST(0).
- R7: A register binary compute (op=5) writes `res_data` into ST(0) when `cmd_rev` is 0. When `cmd_rev` is 1 it writes into ST(`cmd_idx`) and leaves ST(0) unchanged. An offset of 1 gives the implicit ST(0)/ST(1) pairing.
- R8: An external binary compute (op=6) pairs ST(0) with `ext_data` and writes `res_data` into ST(0).
- R9: A compute (op 4 to 6) with `cmd_pop` set writes its result first and then pops. A result aimed at ST(1) therefore becomes the new ST(0).
- R10: A compute or exchange that reads an empty entry sets the underflow flag and leaves the data, the tags and the pointer unchanged.
- R11: Both flags are sticky: once set, they stay set until reset. Op=0 is a no-op.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 3 | Command: 0 nop, 1 push, 2 pop, 3 exchange, 4 unary, 5 register binary, 6 external binary |
| cmd_idx | input | 3 | Offset i of ST(i) |
| cmd_rev | input | 1 | Reverse destination for register binary |
| cmd_pop | input | 1 | Pop after a compute |
| push_data | input | 80 | Value to push |
| ext_data | input | 80 | Outside operand for external binary |
| res_data | input | 80 | Result returned by the arithmetic unit |
| opa | output | 80 | First operand, ST(0) |
| opb | output | 80 | Second operand, ST(i) or ext_data |
| top_ptr | output | 3 | Current top pointer |
| tag_valid | output | 8 | Valid tags by physical entry |
| ovf_flag | output | 1 | Sticky overflow |
| unf_flag | output | 1 | Sticky underflow |

## Verification
In a compute-and-pop command, the result write and the pop land on the same clock edge, and they can target neighbouring physical entries. The bench provokes this with a reverse binary compute into ST(1) with the pop bit set. It judges the outcome by reading the new ST(0) through `opb` and comparing it with the returned result. It also checks that the pointer advanced by one and that the old top's tag is cleared. The bench also sweeps exchanges and reverse and non-reverse binary computes over every offset, and compares every entry against an arithmetic model after each command.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;
    localparam int NREG = 8;
    localparam int FW   = 80;
    localparam int PW   = $clog2(NREG);

    typedef logic [PW-1:0] ptr_t;
    typedef logic [FW-1:0] val_t;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_PUSH   = 3'd1,
        OP_POP    = 3'd2,
        OP_XCHG   = 3'd3,
        OP_UNARY  = 3'd4,
        OP_BINREG = 3'd5,
        OP_BINEXT = 3'd6
    } op_e;

    typedef struct packed {
        logic wr_a_en;
        ptr_t wr_a_idx;
        val_t wr_a_data;
        logic wr_b_en;
        ptr_t wr_b_idx;
        val_t wr_b_data;
        logic set_valid;
        ptr_t set_idx;
        logic clr_valid;
        ptr_t clr_idx;
    } upd_t;

    function automatic ptr_t rel_to_phys(ptr_t top, ptr_t off);
        return top + off;
    endfunction
endpackage

// File: rtl/fpstk_ctrl.sv
module fpstk_ctrl
    import fpstk_pkg::*;
(
    input  op_e              op,
    input  ptr_t             idx,
    input  logic             rev,
    input  logic             pop_after,
    input  ptr_t             top,
    input  logic [NREG-1:0]  tags,
    input  val_t             st0,
    input  val_t             sti,
    input  val_t             push_data,
    input  val_t             res_data,
    output upd_t             upd,
    output ptr_t             top_n,
    output logic             ovf_set,
    output logic             unf_set
);
    ptr_t p_i;
    ptr_t p_dn;
    logic need_pop;

    assign p_i  = rel_to_phys(top, idx);
    assign p_dn = top - ptr_t'(1);

    always_comb begin
        upd      = '0;
        top_n    = top;
        ovf_set  = 1'b0;
        unf_set  = 1'b0;
        need_pop = 1'b0;
        case (op)
            OP_PUSH: begin
                if (tags[p_dn]) begin
                    ovf_set = 1'b1;
                end else begin
                    upd.wr_a_en   = 1'b1;
                    upd.wr_a_idx  = p_dn;
                    upd.wr_a_data = push_data;
                    upd.set_valid = 1'b1;
                    upd.set_idx   = p_dn;
                    top_n         = p_dn;
                end
            end
            OP_POP: begin
                if (!tags[top]) unf_set = 1'b1;
                else            need_pop = 1'b1;
            end
            OP_XCHG: begin
                if (!(tags[top] && tags[p_i])) begin
                    unf_set = 1'b1;
                end else begin
                    upd.wr_a_en   = 1'b1;
                    upd.wr_a_idx  = top;
                    upd.wr_a_data = sti;
                    upd.wr_b_en   = 1'b1;
                    upd.wr_b_idx  = p_i;
                    upd.wr_b_data = st0;
                end
            end
            OP_UNARY, OP_BINEXT: begin
                if (!tags[top]) begin
                    unf_set = 1'b1;
                end else begin
                    upd.wr_a_en   = 1'b1;
                    upd.wr_a_idx  = top;
                    upd.wr_a_data = res_data;
                    need_pop      = pop_after;
                end
            end
            OP_BINREG: begin
                if (!(tags[top] && tags[p_i])) begin
                    unf_set = 1'b1;
                end else begin
                    upd.wr_a_en   = 1'b1;
                    upd.wr_a_idx  = rev ? p_i : top;
                    upd.wr_a_data = res_data;
                    need_pop      = pop_after;
                end
            end
            default: ;
        endcase
        if (need_pop) begin
            upd.clr_valid = 1'b1;
            upd.clr_idx   = top;
            top_n         = top + ptr_t'(1);
        end
    end
endmodule

// File: rtl/fpstk_file.sv
module fpstk_file
    import fpstk_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  upd_t            upd,
    output val_t            data_o [NREG],
    output logic [NREG-1:0] tags_o
);
    for (genvar g = 0; g < NREG; g++) begin : g_ent
        val_t d_q;
        logic t_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                d_q <= '0;
                t_q <= 1'b0;
            end else begin
                if (upd.wr_a_en && upd.wr_a_idx == ptr_t'(g)) d_q <= upd.wr_a_data;
                if (upd.wr_b_en && upd.wr_b_idx == ptr_t'(g)) d_q <= upd.wr_b_data;
                if (upd.set_valid && upd.set_idx == ptr_t'(g)) t_q <= 1'b1;
                if (upd.clr_valid && upd.clr_idx == ptr_t'(g)) t_q <= 1'b0;
            end
        end
        assign data_o[g] = d_q;
        assign tags_o[g] = t_q;
    end
endmodule

// File: rtl/fpstk_state.sv
module fpstk_state
    import fpstk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ptr_t top_n,
    input  logic ovf_set,
    input  logic unf_set,
    output ptr_t top_q,
    output logic ovf_q,
    output logic unf_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            top_q <= '0;
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            top_q <= top_n;
            ovf_q <= ovf_q | ovf_set;
            unf_q <= unf_q | unf_set;
        end
    end
endmodule

// File: rtl/fp_regstack.sv
module fp_regstack
    import fpstk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [2:0]           cmd_op,
    input  logic [PW-1:0]        cmd_idx,
    input  logic                 cmd_rev,
    input  logic                 cmd_pop,
    input  logic [FW-1:0]        push_data,
    input  logic [FW-1:0]        ext_data,
    input  logic [FW-1:0]        res_data,
    output logic [FW-1:0]        opa,
    output logic [FW-1:0]        opb,
    output logic [PW-1:0]        top_ptr,
    output logic [NREG-1:0]      tag_valid,
    output logic                 ovf_flag,
    output logic                 unf_flag
);
    op_e             op;
    ptr_t            top_q;
    ptr_t            top_n;
    ptr_t            p_i;
    val_t            st_q [NREG];
    logic [NREG-1:0] tags_q;
    val_t            st0;
    val_t            sti;
    upd_t            upd;
    logic            ovf_set;
    logic            unf_set;

    assign op  = op_e'(cmd_op);
    assign p_i = rel_to_phys(top_q, cmd_idx);
    assign st0 = st_q[top_q];
    assign sti = st_q[p_i];

    fpstk_ctrl u_ctrl (
        .op        (op),
        .idx       (cmd_idx),
        .rev       (cmd_rev),
        .pop_after (cmd_pop),
        .top       (top_q),
        .tags      (tags_q),
        .st0       (st0),
        .sti       (sti),
        .push_data (push_data),
        .res_data  (res_data),
        .upd       (upd),
        .top_n     (top_n),
        .ovf_set   (ovf_set),
        .unf_set   (unf_set)
    );

    fpstk_file u_file (
        .clk    (clk),
        .rst    (rst),
        .upd    (upd),
        .data_o (st_q),
        .tags_o (tags_q)
    );

    fpstk_state u_state (
        .clk     (clk),
        .rst     (rst),
        .top_n   (top_n),
        .ovf_set (ovf_set),
        .unf_set (unf_set),
        .top_q   (top_q),
        .ovf_q   (ovf_flag),
        .unf_q   (unf_flag)
    );

    assign opa       = st0;
    assign opb       = (op == OP_BINEXT) ? ext_data : sti;
    assign top_ptr   = top_q;
    assign tag_valid = tags_q;
endmodule

// File: rtl/fpstk_sva.sv
module fpstk_sva
    import fpstk_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [2:0]      cmd_op,
    input logic [PW-1:0]   cmd_idx,
    input logic [PW-1:0]   top_ptr,
    input logic [NREG-1:0] tag_valid,
    input logic            ovf_flag,
    input logic            unf_flag
);
    ptr_t below;
    ptr_t rel;
    assign below = top_ptr - ptr_t'(1);
    assign rel   = top_ptr + cmd_idx;

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (top_ptr == '0 && tag_valid == '0 && !ovf_flag && !unf_flag));

    assert_push_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == OP_PUSH && !tag_valid[below]) |=>
            (top_ptr == $past(below) && tag_valid[top_ptr]));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == OP_PUSH && tag_valid[below]) |=>
            (ovf_flag && $stable(top_ptr) && $stable(tag_valid)));

    assert_pop_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == OP_POP && tag_valid[top_ptr]) |=>
            (top_ptr == $past(top_ptr) + ptr_t'(1) && !tag_valid[$past(top_ptr)]));

    assert_xchg_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == OP_XCHG) |=> ($stable(top_ptr) && $stable(tag_valid)));

    assert_empty_read_R10: assert property (@(posedge clk) disable iff (rst)
        ((cmd_op == OP_UNARY || cmd_op == OP_BINEXT ||
          ((cmd_op == OP_BINREG || cmd_op == OP_XCHG) && !tag_valid[rel]))
         && !tag_valid[top_ptr]) |=>
            (unf_flag && $stable(top_ptr) && $stable(tag_valid)));

    assert_sticky_ovf_R11: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> ovf_flag);

    assert_sticky_unf_R11: assert property (@(posedge clk) disable iff (rst)
        unf_flag |=> unf_flag);
endmodule

bind fp_regstack fpstk_sva u_sva (
    .clk       (clk),
    .rst       (rst),
    .cmd_op    (cmd_op),
    .cmd_idx   (cmd_idx),
    .top_ptr   (top_ptr),
    .tag_valid (tag_valid),
    .ovf_flag  (ovf_flag),
    .unf_flag  (unf_flag)
);

// File: tb/tb_fp_regstack.sv
module tb_fp_regstack;
    import fpstk_pkg::*;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [2:0]      cmd_op = 3'd0;
    logic [PW-1:0]   cmd_idx = '0;
    logic            cmd_rev = 1'b0;
    logic            cmd_pop = 1'b0;
    logic [FW-1:0]   push_data = '0;
    logic [FW-1:0]   ext_data = '0;
    logic [FW-1:0]   res_data = '0;
    logic [FW-1:0]   opa;
    logic [FW-1:0]   opb;
    logic [PW-1:0]   top_ptr;
    logic [NREG-1:0] tag_valid;
    logic            ovf_flag;
    logic            unf_flag;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [FW-1:0]   m_val [NREG];
    logic [NREG-1:0] m_tag;
    logic [PW-1:0]   m_top;
    logic            m_ovf;
    logic            m_unf;

    always #5 clk = ~clk;

    fp_regstack dut (
        .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
        .cmd_rev(cmd_rev), .cmd_pop(cmd_pop), .push_data(push_data),
        .ext_data(ext_data), .res_data(res_data), .opa(opa), .opb(opb),
        .top_ptr(top_ptr), .tag_valid(tag_valid), .ovf_flag(ovf_flag),
        .unf_flag(unf_flag)
    );

    function automatic logic [FW-1:0] mkval(int k);
        return {16'(16'h3FF0 + k), 64'hC000_0000_0000_0000 | 64'(k * 977)};
    endfunction

    task automatic chk(string req, logic [FW-1:0] act, logic [FW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare pointer, tags, flags and every valid entry (read via opb) with the model
    task automatic check_state(string req);
        cmd_op = OP_NOP;
        chk(req, FW'(top_ptr), FW'(m_top));
        chk(req, FW'(tag_valid), FW'(m_tag));
        chk(req, FW'(ovf_flag), FW'(m_ovf));
        chk(req, FW'(unf_flag), FW'(m_unf));
        for (int i = 0; i < NREG; i++) begin
            cmd_idx = PW'(i);
            #1;
            if (m_tag[PW'(m_top + PW'(i))])
                chk(req, opb, m_val[PW'(m_top + PW'(i))]);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cmd_op = OP_NOP;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_tag = '0; m_top = '0; m_ovf = 1'b0; m_unf = 1'b0;
        for (int i = 0; i < NREG; i++) m_val[i] = '0;
    endtask

    // Model from the requirements, applied on the edge
    task automatic model(op_e op, int idx, bit rev, bit pp);
        logic [PW-1:0] p0, pi, pd;
        logic [FW-1:0] t;
        bit np;
        p0 = m_top; pi = PW'(m_top + PW'(idx)); pd = PW'(m_top - 1);
        np = 1'b0;
        case (op)
            OP_PUSH: if (m_tag[pd]) m_ovf = 1'b1;
                     else begin m_val[pd] = push_data; m_tag[pd] = 1'b1; m_top = pd; end
            OP_POP:  if (!m_tag[p0]) m_unf = 1'b1; else np = 1'b1;
            OP_XCHG: if (!(m_tag[p0] && m_tag[pi])) m_unf = 1'b1;
                     else begin t = m_val[p0]; m_val[p0] = m_val[pi]; m_val[pi] = t; end
            OP_UNARY, OP_BINEXT:
                     if (!m_tag[p0]) m_unf = 1'b1;
                     else begin m_val[p0] = res_data; np = pp; end
            OP_BINREG:
                     if (!(m_tag[p0] && m_tag[pi])) m_unf = 1'b1;
                     else begin
                         if (rev) m_val[pi] = res_data; else m_val[p0] = res_data;
                         np = pp;
                     end
            default: ;
        endcase
        if (np) begin m_tag[p0] = 1'b0; m_top = PW'(p0 + 1); end
    endtask

    task automatic cmd(string req, op_e op, int idx, bit rev, bit pp,
                       logic [FW-1:0] pd, logic [FW-1:0] ed, logic [FW-1:0] rd);
        @(negedge clk);
        cmd_op = op; cmd_idx = PW'(idx); cmd_rev = rev; cmd_pop = pp;
        push_data = pd; ext_data = ed; res_data = rd;
        #1;
        if (op == OP_BINEXT) chk("R8", opb, ed);
        if ((op == OP_BINREG || op == OP_UNARY) && m_tag[m_top]) begin
            chk("R2", opa, m_val[m_top]);
            if (m_tag[PW'(m_top + PW'(idx))])
                chk("R2", opb, m_val[PW'(m_top + PW'(idx))]);
        end
        @(posedge clk);
        #1;
        model(op, idx, rev, pp);
        check_state(req);
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) m_val[i] = '0;
        m_tag = '0; m_top = '0; m_ovf = 1'b0; m_unf = 1'b0;
        do_reset();
        #1;
        check_state("R1");

        // R4 / R10: pop and compute on an empty stack
        cmd("R4", OP_POP, 0, 0, 0, '0, '0, '0);
        cmd("R10", OP_UNARY, 0, 0, 0, '0, '0, mkval(99));
        cmd("R11", OP_NOP, 0, 0, 0, '0, '0, '0);
        cmd("R11", OP_NOP, 3, 0, 0, '0, '0, '0);
        do_reset();
        #1;
        check_state("R1");

        // R3: fill all eight, then overflow
        for (int k = 0; k < NREG; k++) cmd("R3", OP_PUSH, 0, 0, 0, mkval(k), '0, '0);
        cmd("R3", OP_PUSH, 0, 0, 0, mkval(50), '0, '0);
        cmd("R11", OP_POP, 0, 0, 0, '0, '0, '0);
        cmd("R11", OP_NOP, 0, 0, 0, '0, '0, '0);

        // R5 / R10: exchange sweep on a partly filled stack
        do_reset();
        for (int k = 0; k < 4; k++) cmd("R3", OP_PUSH, 0, 0, 0, mkval(10 + k), '0, '0);
        for (int i = 0; i < 4; i++) cmd("R5", OP_XCHG, i, 0, 0, '0, '0, '0);
        cmd("R10", OP_XCHG, 5, 0, 0, '0, '0, '0);
        cmd("R10", OP_BINREG, 6, 1, 0, '0, '0, mkval(77));

        // R6 / R7 / R8: computes over every offset on a full stack
        do_reset();
        for (int k = 0; k < NREG; k++) cmd("R3", OP_PUSH, 0, 0, 0, mkval(20 + k), '0, '0);
        for (int i = 0; i < NREG; i++) begin
            cmd("R7", OP_BINREG, i, 0, 0, '0, '0, mkval(100 + i));
            cmd("R7", OP_BINREG, i, 1, 0, '0, '0, mkval(200 + i));
        end
        cmd("R6", OP_UNARY, 0, 0, 0, '0, '0, mkval(300));
        cmd("R8", OP_BINEXT, 4, 0, 0, '0, mkval(400), mkval(401));

        // R9: result to ST(1) with pop in the same edge
        cmd("R9", OP_BINREG, 1, 1, 1, '0, '0, mkval(500));
        chk("R9", opa, mkval(500));
        cmd("R9", OP_UNARY, 0, 0, 1, '0, '0, mkval(501));
        cmd("R9", OP_BINEXT, 0, 0, 1, '0, mkval(502), mkval(503));

        // R4: pop to empty, then underflow
        for (int k = 0; k < 6; k++) cmd("R4", OP_POP, 0, 0, 0, '0, '0, '0);
        cmd("R4", OP_POP, 0, 0, 0, '0, '0, '0);

        // R1: reset in the middle clears everything
        cmd("R3", OP_PUSH, 0, 0, 0, mkval(600), '0, '0);
        do_reset();
        #1;
        check_state("R1");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule